// File: doc/BRIEF.md
# ADC Overload Flag and Startup Output Mute

This block sits behind the decimation and DC-removal stages of a stereo audio ADC. Each frame it receives a strobe with one signed left and one signed right sample. It drives two outputs: an overload flag for record-level control, and an enable that keeps the serial data output forced low while the filters settle.

A sample counts as overloaded when its magnitude is above a fixed level just under full scale. The most negative code saturates to the largest positive magnitude, so it counts as an overload. The flag then stays high for a hold period measured in sample strobes, and each further overloaded sample starts that period again.

After reset, and after each restart pulse, the output enable stays low until a number of strobes has arrived. That number is longer when the DC-cancellation filter is enabled, because that filter takes longer to settle. A restart is raised on recovery from power-down or when the system clock is switched on.

Top module: `adc_guard`

## Requirements
- R1: A strobed sample overloads when the magnitude of either channel is strictly greater than 7·2^(SMP_W-4), which is 458752 (0x70000) for 20-bit samples. A magnitude equal to that level does not overload.
- R2: Samples are two's complement. The most negative code (0x80000) counts as an overload. The code -458752 (0x90000) does not, and -458753 (0x8FFFF) does.
- R3: At the clock edge that takes an overloaded strobe, ovl_flag goes high, so it reads high in the following cycle.
- R4: Once the last overloaded sample has arrived, ovl_flag stays high through the next HOLD_SMPS-1 (511) clean strobes and goes low at the HOLD_SMPS-th (512th).
- R5: Every new overloaded sample reloads the full hold, even while the flag is already high.
- R6: Cycles with smp_stb low are ignored. The sample values in those cycles neither set the flag nor advance either count.
- R7: After reset or a restart pulse, sdo_en is low. With dcf_en low it rises at the MUTE_PLAIN-th (1024th) strobe that follows.
- R8: With dcf_en high, sdo_en rises at the MUTE_DCF-th (12288th) strobe that follows the restart.
- R9: A change of dcf_en while the mute is running restarts the mute with the full length for the new value. A change after sdo_en has risen has no effect.
- R10: A restart pulse clears ovl_flag. It takes priority over a strobe in the same cycle: that strobe neither sets the flag nor counts toward the mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe per sample frame |
| smp_left | input | SMP_W | Left sample, two's complement |
| smp_right | input | SMP_W | Right sample, two's complement |
| dcf_en | input | 1 | DC-cancellation filter enabled; selects the mute length |
| restart | input | 1 | Restart pulse on power-up recovery or clock start |
| ovl_flag | output | 1 | Stretched overload flag |
| sdo_en | output | 1 | Serial data enable; low while output is muted |

## Verification
The bench probes the threshold from both sides in each channel, including the most negative code. An off-by-one compare or a non-saturating absolute value would flip one of those vectors. The hold and both mute lengths are checked one strobe before and exactly at their ends, so a counter that is one too long or too short is caught. The bench also retriggers the flag part way through a hold, and changes dcf_en part way through a short mute; a design that ignores either would release its output hundreds or thousands of strobes early. A restart is issued in the same cycle as an overloaded strobe, which shows a wrong priority as a set flag or as a mute that ends one strobe early.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;

    // Events that change the overload hold counter.
    typedef enum logic [1:0] {
        HOLD_IDLE  = 2'd0,
        HOLD_DECAY = 2'd1,
        HOLD_LOAD  = 2'd2,
        HOLD_CLEAR = 2'd3
    } hold_ev_e;

    // Events that change the mute counter.
    typedef enum logic [1:0] {
        MUTE_KEEP   = 2'd0,
        MUTE_STEP   = 2'd1,
        MUTE_RELOAD = 2'd2
    } mute_ev_e;

    // The overload level is 7/8 of full scale for a w-bit signed sample.
    function automatic int ovl_level(input int w);
        return 7 << (w - 4);
    endfunction

    // The mute length depends on whether the DC filter is enabled.
    function automatic int mute_len(input logic dcf, input int plain, input int dcf_len);
        return dcf ? dcf_len : plain;
    endfunction

endpackage

// File: rtl/ovl_level_cmp.sv
module ovl_level_cmp
    import adc_guard_pkg::*;
#(
    parameter int SMP_W = 20,
    parameter int NCH   = 2
) (
    input  logic [NCH*SMP_W-1:0] smp_bus,
    output logic                 hit
);
    localparam logic [SMP_W-1:0] LEVEL   = SMP_W'(ovl_level(SMP_W));
    localparam logic [SMP_W-1:0] MOSTNEG = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] MOSTPOS = {1'b0, {(SMP_W-1){1'b1}}};

    logic [NCH-1:0] ch_hit;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SMP_W-1:0] raw;
        logic [SMP_W-1:0] mag;
        assign raw = smp_bus[c*SMP_W +: SMP_W];
        always_comb begin
            if (raw == MOSTNEG)     mag = MOSTPOS;
            else if (raw[SMP_W-1]) mag = ~raw + SMP_W'(1);
            else                   mag = raw;
        end
        assign ch_hit[c] = (mag > LEVEL);

        // R2
        always_comb begin
            if (raw == MOSTNEG) begin
                mostneg_hit_chk: assert (ch_hit[c] !== 1'b0);
            end
        end
    end

    assign hit = |ch_hit;

endmodule

// File: rtl/ovl_hold_timer.sv
module ovl_hold_timer
    import adc_guard_pkg::*;
#(
    parameter int HOLD_LEN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic stb,
    input  logic hit,
    output logic flag
);
    localparam int CW = $clog2(HOLD_LEN + 1);

    logic [CW-1:0] cnt;
    hold_ev_e      ev;

    always_comb begin
        if (restart)                  ev = HOLD_CLEAR;
        else if (stb && hit)          ev = HOLD_LOAD;
        else if (stb && cnt != '0)    ev = HOLD_DECAY;
        else                          ev = HOLD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (ev)
                HOLD_CLEAR: cnt <= '0;
                HOLD_LOAD:  cnt <= CW'(HOLD_LEN);
                HOLD_DECAY: cnt <= cnt - CW'(1);
                default:    cnt <= cnt;
            endcase
        end
    end

    assign flag = (cnt != '0);

    // R3
    ovl_set_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && hit && !restart) |=> flag);

    // R10
    ovl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !flag);

    // R4
    ovl_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> ($past(stb) || $past(restart)));

    // R6
    ovl_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb && !restart) |=> $stable(flag));

endmodule

// File: rtl/out_mute_timer.sv
module out_mute_timer
    import adc_guard_pkg::*;
#(
    parameter int MUTE_PLAIN = 1024,
    parameter int MUTE_DCF   = 12288
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic stb,
    input  logic dcf_en,
    output logic sdo_en
);
    localparam int MAXLEN = (MUTE_DCF > MUTE_PLAIN) ? MUTE_DCF : MUTE_PLAIN;
    localparam int CW     = $clog2(MAXLEN + 1);

    logic [CW-1:0] cnt;
    logic          dcf_q;
    logic [CW-1:0] len_now;
    mute_ev_e      ev;

    assign len_now = CW'(mute_len(dcf_en, MUTE_PLAIN, MUTE_DCF));

    always_comb begin
        if (restart || (cnt != '0 && dcf_en != dcf_q)) ev = MUTE_RELOAD;
        else if (stb && cnt != '0)                     ev = MUTE_STEP;
        else                                           ev = MUTE_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= len_now;
            dcf_q <= dcf_en;
        end else begin
            dcf_q <= dcf_en;
            case (ev)
                MUTE_RELOAD: cnt <= len_now;
                MUTE_STEP:   cnt <= cnt - CW'(1);
                default:     cnt <= cnt;
            endcase
        end
    end

    assign sdo_en = (cnt == '0);

    // R7
    mute_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !sdo_en);

    // R6
    mute_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb && !restart) |=> $stable(sdo_en));

    // R8
    mute_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> $past(stb));

    // R9
    mute_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_en && !restart) |=> sdo_en);

endmodule

// File: rtl/adc_guard.sv
module adc_guard
    import adc_guard_pkg::*;
#(
    parameter int SMP_W      = 20,
    parameter int HOLD_SMPS  = 512,
    parameter int MUTE_PLAIN = 1024,
    parameter int MUTE_DCF   = 12288
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_stb,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    input  logic             dcf_en,
    input  logic             restart,
    output logic             ovl_flag,
    output logic             sdo_en
);
    localparam int NCH = 2;

    logic [NCH*SMP_W-1:0] smp_bus;
    logic                 lvl_hit;

    assign smp_bus = {smp_right, smp_left};

    ovl_level_cmp #(.SMP_W(SMP_W), .NCH(NCH)) u_cmp (
        .smp_bus (smp_bus),
        .hit     (lvl_hit)
    );

    ovl_hold_timer #(.HOLD_LEN(HOLD_SMPS)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .stb     (smp_stb),
        .hit     (lvl_hit),
        .flag    (ovl_flag)
    );

    out_mute_timer #(.MUTE_PLAIN(MUTE_PLAIN), .MUTE_DCF(MUTE_DCF)) u_mute (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .stb     (smp_stb),
        .dcf_en  (dcf_en),
        .sdo_en  (sdo_en)
    );

endmodule

// File: tb/adc_guard_tb_top.sv
`timescale 1ns/1ps
module adc_guard_tb_top;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_stb = 1'b0;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic         dcf_en = 1'b0;
    logic         restart = 1'b0;
    logic         ovl_flag;
    logic         sdo_en;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    adc_guard dut_i (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_left(smp_left),
        .smp_right(smp_right), .dcf_en(dcf_en), .restart(restart),
        .ovl_flag(ovl_flag), .sdo_en(sdo_en)
    );

    // {expected flag, left, right}; level 0x70000, most negative 0x80000
    localparam logic [2*W:0] VEC [10] = '{
        {1'b0, 20'h70000, 20'h00000},
        {1'b1, 20'h70001, 20'h00000},
        {1'b1, 20'h00000, 20'h70001},
        {1'b0, 20'h90000, 20'h90000},
        {1'b1, 20'h00000, 20'h8FFFF},
        {1'b1, 20'h80000, 20'h00000},
        {1'b1, 20'h00000, 20'h80000},
        {1'b0, 20'h6FFFF, 20'hFFFFF},
        {1'b1, 20'h7FFFF, 20'h7FFFF},
        {1'b0, 20'h00000, 20'h00000}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic strobe(input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        smp_stb = 1'b1; smp_left = l; smp_right = r;
        @(negedge clk);
        smp_stb = 1'b0; smp_left = '0; smp_right = '0;
    endtask

    task automatic run_quiet(input int n);
        @(negedge clk);
        smp_left = '0; smp_right = '0;
        smp_stb = 1'b1;
        repeat (n) @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset flag", ovl_flag, 1'b0);
        chk("R7 reset mute", sdo_en, 1'b0);

        // R1 R2 R3 threshold table
        for (int i = 0; i < 10; i++) begin
            pulse_restart();
            strobe(VEC[i][2*W-1:W], VEC[i][W-1:0]);
            chk($sformatf("R1 R2 R3 vector %0d", i), ovl_flag, VEC[i][2*W]);
        end

        // R7 short mute after restart
        pulse_restart();
        run_quiet(1023);
        chk("R7 before end", sdo_en, 1'b0);
        run_quiet(1);
        chk("R7 at end", sdo_en, 1'b1);

        // R6 unstrobed samples ignored
        @(negedge clk);
        smp_left = 20'h80000; smp_right = 20'h7FFFF;
        repeat (5) @(negedge clk);
        smp_left = '0; smp_right = '0;
        chk("R6 no strobe", ovl_flag, 1'b0);

        // R4 hold length
        strobe(20'h7FFFF, 20'h0);
        run_quiet(511);
        chk("R4 hold before end", ovl_flag, 1'b1);
        run_quiet(1);
        chk("R4 hold at end", ovl_flag, 1'b0);

        // R5 retrigger
        strobe(20'h7FFFF, 20'h0);
        run_quiet(300);
        strobe(20'h0, 20'h80000);
        run_quiet(511);
        chk("R5 retrigger held", ovl_flag, 1'b1);
        run_quiet(1);
        chk("R5 retrigger end", ovl_flag, 1'b0);

        // R8 long mute
        dcf_en = 1'b1;
        pulse_restart();
        run_quiet(12287);
        chk("R8 before end", sdo_en, 1'b0);
        run_quiet(1);
        chk("R8 at end", sdo_en, 1'b1);

        // R9 change after mute ends has no effect
        @(negedge clk);
        dcf_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 change after end", sdo_en, 1'b1);

        // R9 change during mute reloads long length
        pulse_restart();
        run_quiet(500);
        @(negedge clk);
        dcf_en = 1'b1;
        repeat (2) @(negedge clk);
        run_quiet(12287);
        chk("R9 reload before end", sdo_en, 1'b0);
        run_quiet(1);
        chk("R9 reload at end", sdo_en, 1'b1);

        // R10 restart clears flag and beats same-cycle strobe
        dcf_en = 1'b0;
        repeat (2) @(negedge clk);
        strobe(20'h7FFFF, 20'h0);
        chk("R10 flag set first", ovl_flag, 1'b1);
        @(negedge clk);
        restart = 1'b1; smp_stb = 1'b1; smp_left = 20'h80000;
        @(negedge clk);
        restart = 1'b0; smp_stb = 1'b0; smp_left = '0;
        chk("R10 flag cleared", ovl_flag, 1'b0);
        chk("R10 muted", sdo_en, 1'b0);
        run_quiet(1023);
        chk("R10 strobe not counted", sdo_en, 1'b0);
        run_quiet(1);
        chk("R10 mute end", sdo_en, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule